// File: doc/BRIEF.md
# Command ring parser

The block pulls drawing commands out of a producer/consumer ring that lives in shared memory made of 32-bit words. It sees that memory through one word-addressed read port, which returns data one cycle after a request, and one write port. The first four words of the region are control words. Word 0 is the ring floor and word 1 is the ring ceiling. Word 2 is the producer (next-command) pointer and word 3 is the consumer (stop) pointer. All pointers are byte offsets. Software writes commands into the ring and moves the producer pointer. The parser consumes from the consumer pointer until the two pointers match.

For each command the parser reads the opcode word and looks up that opcode's fixed argument count. It collects that many argument words and presents the opcode and the arguments on a valid/ready output. Once the command is accepted, the parser writes the advanced consumer pointer back to word 3. An opcode it cannot parse raises a one-cycle error and discards everything up to the producer pointer. A sync request raises `busy`, which stays high until the ring is drained and the last command has been handed over.

State machine: `S_IDLE` always moves to `S_POLL_REQ`. `S_POLL_REQ` goes to `S_POLL_CAP`, which loops back to `S_POLL_REQ` until all four control words are read and then goes to `S_CHECK`. `S_CHECK` returns to `S_IDLE` when the pointers are equal and otherwise goes to `S_OP_REQ`. `S_OP_REQ` goes to `S_OP_CAP`, which goes to `S_ARG_REQ` for a known opcode or to `S_ERR` for an unknown one. `S_ARG_REQ` goes to `S_ARG_CAP`, which loops back to `S_ARG_REQ` until the last argument and then goes to `S_EMIT`. `S_EMIT` waits for `cmd_ready` and then goes to `S_WB`. `S_WB` goes to `S_POLL_REQ`, and so does `S_ERR`.

Top module: `cmdp_ring_parser`

## Requirements
- R1: Control word layout: word 0 = ring floor, word 1 = ring ceiling, word 2 = producer pointer, word 3 = consumer pointer. All are byte offsets, and the word address is the byte offset shifted right by 2. Read data arrives one cycle after `mem_rd_en`. Commands are parsed starting at the consumer pointer and stop when it equals the producer pointer. Read and write are never requested in the same cycle.
- R2: Argument word counts per opcode: 1→4, 2→5, 3→6, 8→7, 9→5, 10→9, 11→7, 12→1, 13→6, 14→7, 15→8, 16→6, 17→10, 18→8, 20→2, 21→2, 25→5, 26→7, 27→9, 28→12. `cmd_op` carries the opcode and `cmd_nargs` the count. Argument k sits in `cmd_args[32k+31:32k]`, and unused slots are zero.
- R3: Opcode 0, any opcode of 29 or above, and the variable-length opcodes 4, 5, 6, 7, 19, 22, 23 and 24 are invalid. For an invalid opcode `err_pulse` is high for exactly one cycle, no command is emitted, and word 3 is written with the producer pointer.
- R4: Each pointer step adds 4 bytes. A result at or above the ceiling wraps to the floor, and this applies in the middle of a command as well.
- R5: After a command is accepted, the consumer pointer just past it is written to word 3 before the next opcode is read. All writes target word 3.
- R6: While `cmd_valid` is high and `cmd_ready` is low, `cmd_valid`, `cmd_op`, `cmd_nargs` and `cmd_args` stay unchanged.
- R7: For opcodes 13–18, 26 and 27 the last argument is a raster op. `cmd_rop_bad` is 1 when that value is 16 or more, and 0 otherwise and for all other opcodes.
- R8: `sync_req` sampled high sets `busy` on the next cycle. `busy` clears only after a check finds the consumer pointer equal to the producer pointer, which happens only once every emitted command has been accepted.
- R9: During and right after reset, `cmd_valid`, `err_pulse`, `busy`, `mem_rd_en` and `mem_wr_en` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mem_rd_en | output | 1 | Memory read request |
| mem_rd_addr | output | AW | Word address of read |
| mem_rd_data | input | 32 | Read data, one cycle after request |
| mem_wr_en | output | 1 | Memory write request |
| mem_wr_addr | output | AW | Word address of write |
| mem_wr_data | output | 32 | Write data |
| cmd_valid | output | 1 | Parsed command available |
| cmd_ready | input | 1 | Consumer accepts command |
| cmd_op | output | 5 | Opcode |
| cmd_nargs | output | 4 | Number of argument words |
| cmd_args | output | 384 | Argument words, slot k in bits 32k+31:32k |
| cmd_rop_bad | output | 1 | Raster-op argument out of range |
| err_pulse | output | 1 | One-cycle invalid-opcode flag |
| sync_req | input | 1 | Drain request |
| busy | output | 1 | Drain in progress |

## Verification
A wrong argument count or a wrong slot index corrupts the argument words of the command that is being emitted. It then misaligns every command after it, so the first handshake after the fault shows a wrong opcode or wrong arguments. A wrong wrap rule is visible at the first command that crosses the ceiling, both in its argument words and in the value written to word 3 right after the handshake. A stuck busy flag or a lost consumer pointer shows within one poll cycle (about ten clocks) of the ring draining, as `busy` staying high or word 3 not matching word 2.

// File: rtl/cmdp_pkg.sv
package cmdp_pkg;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned OP_W     = 5;
    localparam int unsigned MAX_ARGS = 12;
    localparam int unsigned CNT_W    = $clog2(MAX_ARGS + 1);
    localparam int unsigned OP_LIMIT = 29;
    localparam logic [WORD_W-1:0] ROP_LIMIT = 32'd16;

    typedef enum logic [3:0] {
        S_IDLE,
        S_POLL_REQ,
        S_POLL_CAP,
        S_CHECK,
        S_OP_REQ,
        S_OP_CAP,
        S_ARG_REQ,
        S_ARG_CAP,
        S_EMIT,
        S_WB,
        S_ERR
    } pstate_t;
endpackage

// File: rtl/cmdp_opdec.sv
module cmdp_opdec
    import cmdp_pkg::*;
(
    input  logic [WORD_W-1:0] op_word,
    output logic              op_ok,
    output logic [CNT_W-1:0]  op_nargs,
    output logic              op_has_rop
);
    always_comb begin
        op_nargs   = '0;
        op_has_rop = 1'b0;
        if (op_word < OP_LIMIT) begin
            case (op_word[OP_W-1:0])
                5'd1:  op_nargs = CNT_W'(4);
                5'd2:  op_nargs = CNT_W'(5);
                5'd3:  op_nargs = CNT_W'(6);
                5'd8:  op_nargs = CNT_W'(7);
                5'd9:  op_nargs = CNT_W'(5);
                5'd10: op_nargs = CNT_W'(9);
                5'd11: op_nargs = CNT_W'(7);
                5'd12: op_nargs = CNT_W'(1);
                5'd13: begin op_nargs = CNT_W'(6);  op_has_rop = 1'b1; end
                5'd14: begin op_nargs = CNT_W'(7);  op_has_rop = 1'b1; end
                5'd15: begin op_nargs = CNT_W'(8);  op_has_rop = 1'b1; end
                5'd16: begin op_nargs = CNT_W'(6);  op_has_rop = 1'b1; end
                5'd17: begin op_nargs = CNT_W'(10); op_has_rop = 1'b1; end
                5'd18: begin op_nargs = CNT_W'(8);  op_has_rop = 1'b1; end
                5'd20: op_nargs = CNT_W'(2);
                5'd21: op_nargs = CNT_W'(2);
                5'd25: op_nargs = CNT_W'(5);
                5'd26: begin op_nargs = CNT_W'(7);  op_has_rop = 1'b1; end
                5'd27: begin op_nargs = CNT_W'(9);  op_has_rop = 1'b1; end
                5'd28: op_nargs = CNT_W'(12);
                default: op_nargs = '0;
            endcase
        end
        op_ok = (op_nargs != '0);
    end
endmodule

// File: rtl/cmdp_ptr_step.sv
module cmdp_ptr_step
    import cmdp_pkg::*;
(
    input  logic [WORD_W-1:0] cur,
    input  logic [WORD_W-1:0] floor_ptr,
    input  logic [WORD_W-1:0] ceil_ptr,
    output logic [WORD_W-1:0] nxt
);
    localparam int unsigned STEP = WORD_W / 8;
    logic [WORD_W:0] sum;

    always_comb begin
        sum = {1'b0, cur} + (WORD_W+1)'(STEP);
        nxt = (sum >= {1'b0, ceil_ptr}) ? floor_ptr : sum[WORD_W-1:0];
    end
endmodule

// File: rtl/cmdp_arg_bank.sv
module cmdp_arg_bank
    import cmdp_pkg::*;
#(
    parameter int unsigned SLOTS = MAX_ARGS
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     we,
    input  logic [CNT_W-1:0]         idx,
    input  logic [WORD_W-1:0]        din,
    output logic [SLOTS*WORD_W-1:0]  flat
);
    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [WORD_W-1:0] slot_q;
        always_ff @(posedge clk) begin
            if (rst || clr)
                slot_q <= '0;
            else if (we && idx == CNT_W'(g))
                slot_q <= din;
        end
        assign flat[g*WORD_W +: WORD_W] = slot_q;
    end
endmodule

// File: rtl/cmdp_ring_parser.sv
module cmdp_ring_parser
    import cmdp_pkg::*;
#(
    parameter int unsigned AW = 12
) (
    input  logic                       clk,
    input  logic                       rst,
    output logic                       mem_rd_en,
    output logic [AW-1:0]              mem_rd_addr,
    input  logic [WORD_W-1:0]          mem_rd_data,
    output logic                       mem_wr_en,
    output logic [AW-1:0]              mem_wr_addr,
    output logic [WORD_W-1:0]          mem_wr_data,
    output logic                       cmd_valid,
    input  logic                       cmd_ready,
    output logic [OP_W-1:0]            cmd_op,
    output logic [CNT_W-1:0]           cmd_nargs,
    output logic [MAX_ARGS*WORD_W-1:0] cmd_args,
    output logic                       cmd_rop_bad,
    output logic                       err_pulse,
    input  logic                       sync_req,
    output logic                       busy
);
    localparam int unsigned BYTE_SH = $clog2(WORD_W / 8);
    localparam logic [1:0]  IDX_FLOOR = 2'd0;
    localparam logic [1:0]  IDX_CEIL  = 2'd1;
    localparam logic [1:0]  IDX_PROD  = 2'd2;
    localparam logic [1:0]  IDX_CONS  = 2'd3;

    pstate_t            state, state_nx;
    logic [1:0]         ctl_idx;
    logic [WORD_W-1:0]  ring_lo, ring_hi, prod_ptr, cons_ptr, cur_ptr;
    logic [OP_W-1:0]    op_r;
    logic [CNT_W-1:0]   nargs_r, arg_idx;
    logic               has_rop_r, rop_bad_r, busy_r;
    logic               dec_ok, dec_rop, arg_last;
    logic [CNT_W-1:0]   dec_nargs;
    logic [WORD_W-1:0]  step_in, step_out;

    cmdp_opdec u_dec (
        .op_word    (mem_rd_data),
        .op_ok      (dec_ok),
        .op_nargs   (dec_nargs),
        .op_has_rop (dec_rop)
    );

    assign step_in = (state == S_OP_CAP) ? cons_ptr : cur_ptr;

    cmdp_ptr_step u_step (
        .cur       (step_in),
        .floor_ptr (ring_lo),
        .ceil_ptr  (ring_hi),
        .nxt       (step_out)
    );

    cmdp_arg_bank u_bank (
        .clk  (clk),
        .rst  (rst),
        .clr  (state == S_OP_CAP),
        .we   (state == S_ARG_CAP),
        .idx  (arg_idx),
        .din  (mem_rd_data),
        .flat (cmd_args)
    );

    assign arg_last = (arg_idx == nargs_r - CNT_W'(1));

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:     state_nx = S_POLL_REQ;
            S_POLL_REQ: state_nx = S_POLL_CAP;
            S_POLL_CAP: state_nx = (ctl_idx == IDX_CONS) ? S_CHECK : S_POLL_REQ;
            S_CHECK:    state_nx = (cons_ptr != prod_ptr) ? S_OP_REQ : S_IDLE;
            S_OP_REQ:   state_nx = S_OP_CAP;
            S_OP_CAP:   state_nx = dec_ok ? S_ARG_REQ : S_ERR;
            S_ARG_REQ:  state_nx = S_ARG_CAP;
            S_ARG_CAP:  state_nx = arg_last ? S_EMIT : S_ARG_REQ;
            S_EMIT:     state_nx = cmd_ready ? S_WB : S_EMIT;
            S_WB:       state_nx = S_POLL_REQ;
            S_ERR:      state_nx = S_POLL_REQ;
            default:    state_nx = S_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_idx   <= IDX_FLOOR;
            ring_lo   <= '0;
            ring_hi   <= '0;
            prod_ptr  <= '0;
            cons_ptr  <= '0;
            cur_ptr   <= '0;
            op_r      <= '0;
            nargs_r   <= '0;
            arg_idx   <= '0;
            has_rop_r <= 1'b0;
            rop_bad_r <= 1'b0;
        end else begin
            unique case (state)
                S_POLL_CAP: begin
                    unique case (ctl_idx)
                        IDX_FLOOR: ring_lo  <= mem_rd_data;
                        IDX_CEIL:  ring_hi  <= mem_rd_data;
                        IDX_PROD:  prod_ptr <= mem_rd_data;
                        default:   cons_ptr <= mem_rd_data;
                    endcase
                    ctl_idx <= ctl_idx + 2'd1;
                end
                S_OP_CAP: begin
                    op_r      <= mem_rd_data[OP_W-1:0];
                    nargs_r   <= dec_nargs;
                    has_rop_r <= dec_rop;
                    cur_ptr   <= step_out;
                    arg_idx   <= '0;
                    rop_bad_r <= 1'b0;
                end
                S_ARG_CAP: begin
                    cur_ptr <= step_out;
                    arg_idx <= arg_idx + CNT_W'(1);
                    if (arg_last && has_rop_r)
                        rop_bad_r <= (mem_rd_data >= ROP_LIMIT);
                end
                S_WB:    cons_ptr <= cur_ptr;
                S_ERR:   cons_ptr <= prod_ptr;
                default: ;
            endcase
        end
    end

    // drain flag: set wins over clear
    always_ff @(posedge clk) begin
        if (rst)
            busy_r <= 1'b0;
        else if (sync_req)
            busy_r <= 1'b1;
        else if (state == S_CHECK && cons_ptr == prod_ptr)
            busy_r <= 1'b0;
    end

    // outputs
    always_comb begin
        mem_rd_en   = 1'b0;
        mem_rd_addr = '0;
        mem_wr_en   = 1'b0;
        mem_wr_addr = AW'(IDX_CONS);
        mem_wr_data = cur_ptr;
        cmd_valid   = 1'b0;
        err_pulse   = 1'b0;
        unique case (state)
            S_POLL_REQ: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = AW'(ctl_idx);
            end
            S_OP_REQ: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = cons_ptr[AW+BYTE_SH-1:BYTE_SH];
            end
            S_ARG_REQ: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = cur_ptr[AW+BYTE_SH-1:BYTE_SH];
            end
            S_EMIT:  cmd_valid = 1'b1;
            S_WB:    mem_wr_en = 1'b1;
            S_ERR: begin
                mem_wr_en   = 1'b1;
                mem_wr_data = prod_ptr;
                err_pulse   = 1'b1;
            end
            default: ;
        endcase
    end

    assign cmd_op      = op_r;
    assign cmd_nargs   = nargs_r;
    assign cmd_rop_bad = rop_bad_r;
    assign busy        = busy_r;

    // checks
    assert_port_excl_R1: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_en && mem_wr_en));
    assert_nargs_range_R2: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |-> (cmd_nargs != '0) && (cmd_nargs <= CNT_W'(MAX_ARGS)));
    assert_err_single_R3: assert property (@(posedge clk) disable iff (rst)
        err_pulse |=> !err_pulse && !cmd_valid);
    assert_ptr_inside_R4: assert property (@(posedge clk) disable iff (rst)
        (state == S_WB) |-> (cur_ptr >= ring_lo) && (cur_ptr < ring_hi));
    assert_wb_target_R5: assert property (@(posedge clk) disable iff (rst)
        mem_wr_en |-> mem_wr_addr == AW'(IDX_CONS));
    assert_hold_R6: assert property (@(posedge clk) disable iff (rst)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op)
            && $stable(cmd_nargs) && $stable(cmd_args) && $stable(cmd_rop_bad));
    assert_busy_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(sync_req));
    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (rst)
        busy && cmd_valid |=> busy);
endmodule

// File: tb/cmdp_ring_parser_test.sv
module cmdp_ring_parser_test;
    localparam int AW = 12;
    localparam int AB = 384;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mem_rd_en, mem_wr_en;
    logic [AW-1:0] mem_rd_addr, mem_wr_addr;
    logic [31:0] mem_rd_data = '0;
    logic [31:0] mem_wr_data;
    logic cmd_valid, cmd_rop_bad, err_pulse, busy;
    logic cmd_ready = 1'b1;
    logic sync_req = 1'b0;
    logic [4:0] cmd_op;
    logic [3:0] cmd_nargs;
    logic [AB-1:0] cmd_args;

    always #5 clk = ~clk;

    cmdp_ring_parser #(.AW(AW)) uut (
        .clk(clk), .rst(rst),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_nargs(cmd_nargs), .cmd_args(cmd_args), .cmd_rop_bad(cmd_rop_bad),
        .err_pulse(err_pulse), .sync_req(sync_req), .busy(busy)
    );

    logic [31:0] mem [0:4095];
    always @(posedge clk) begin
        if (mem_rd_en) mem_rd_data <= mem[mem_rd_addr];
        if (mem_wr_en) mem[mem_wr_addr] <= mem_wr_data;
    end

    int tests = 0, fails = 0, err_seen = 0, rdy_mode = 0;
    int unsigned lo, hi, pp;
    logic [15:0] lfsr = 16'hACE1;
    int q_op[$], q_n[$];
    bit q_rop[$];
    logic [AB-1:0] q_args[$];

    task automatic check(input bit ok, input string req, input logic [AB-1:0] act, input logic [AB-1:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int ref_nargs(int op);
        case (op)
            1: return 4;   2: return 5;   3: return 6;   8: return 7;
            9: return 5;   10: return 9;  11: return 7;  12: return 1;
            13: return 6;  14: return 7;  15: return 8;  16: return 6;
            17: return 10; 18: return 8;  20: return 2;  21: return 2;
            25: return 5;  26: return 7;  27: return 9;  28: return 12;
            default: return 0;
        endcase
    endfunction

    function automatic bit ref_rop(int op);
        return (op >= 13 && op <= 18) || op == 26 || op == 27;
    endfunction

    function automatic int unsigned adv(int unsigned p);
        return (p + 4 >= hi) ? lo : p + 4;
    endfunction

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic put_word(logic [31:0] w);
        mem[pp >> 2] = w;
        pp = adv(pp);
    endtask

    task automatic commit();
        mem[2] = pp;
    endtask

    // queue an expected command and place it in the ring
    task automatic push_cmd(int op, int seed, logic [31:0] rop_val);
        int n = ref_nargs(op);
        logic [AB-1:0] av = '0;
        put_word(32'(op));
        for (int i = 0; i < n; i++) begin
            logic [31:0] w = (i == n-1 && ref_rop(op)) ? rop_val : 32'((seed << 8) | i);
            av[i*32 +: 32] = w;
            put_word(w);
        end
        q_op.push_back(op); q_n.push_back(n); q_args.push_back(av);
        q_rop.push_back(ref_rop(op) && rop_val >= 16);
        commit();
    endtask

    task automatic init(int unsigned f, int unsigned c, int unsigned start);
        rst = 1'b1;
        lo = f; hi = c; pp = start;
        for (int i = 0; i < 4096; i++) mem[i] = 32'hDEAD0000 | 32'(i);
        mem[0] = f; mem[1] = c; mem[2] = start; mem[3] = start;
        tick(2);
        #3;
        check(!cmd_valid && !err_pulse && !busy && !mem_rd_en && !mem_wr_en, "R9 reset",
              {cmd_valid, err_pulse, busy, mem_rd_en, mem_wr_en}, '0);
        tick(1);
        rst = 1'b0;
        tick(1);
        check(!cmd_valid && !err_pulse && !busy && !mem_wr_en, "R9 after reset",
              {cmd_valid, err_pulse, busy, mem_wr_en}, '0);
    endtask

    task automatic drain(string req);
        int t = 0;
        while ((q_op.size() != 0 || mem[3] != pp) && t < 8000) begin
            tick(1); t++;
        end
        tick(3);
        check(q_op.size() == 0, {req, " all commands seen"}, q_op.size(), 0);
        check(mem[3] == pp, {req, " consumer word"}, mem[3], pp);
    endtask

    // input drivers
    initial forever begin
        @(posedge clk); #2;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cmd_ready = (rdy_mode == 0) ? 1'b1 : (rdy_mode == 1) ? lfsr[0] : 1'b0;
    end

    // per-clock reference comparison
    bit hold_prev = 0;
    logic [4:0] h_op;
    logic [AB-1:0] h_args;
    always @(negedge clk) begin
        if (rst) hold_prev = 0;
        else begin
            if (hold_prev)
                check(cmd_valid && cmd_op == h_op && cmd_args == h_args, "R6 hold",
                      {cmd_valid, cmd_op, cmd_args}, {1'b1, h_op, h_args});
            hold_prev = cmd_valid && !cmd_ready;
            h_op = cmd_op; h_args = cmd_args;
            if (cmd_valid && cmd_ready) begin
                if (q_op.size() == 0)
                    check(0, "R3 unexpected command", cmd_op, 0);
                else begin
                    check(cmd_op == 5'(q_op[0]), "R1 opcode", cmd_op, q_op[0]);
                    check(cmd_nargs == 4'(q_n[0]), "R2 count", cmd_nargs, q_n[0]);
                    check(cmd_args == q_args[0], "R2 args", cmd_args, q_args[0]);
                    check(cmd_rop_bad == q_rop[0], "R7 rop flag", cmd_rop_bad, q_rop[0]);
                    void'(q_op.pop_front()); void'(q_n.pop_front());
                    void'(q_args.pop_front()); void'(q_rop.pop_front());
                end
            end
            if (err_pulse) err_seen++;
            if (mem_wr_en) check(mem_wr_addr == 3, "R5 write target", mem_wr_addr, 3);
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        // R1 R2 R5: assorted commands, ready always high
        init(16, 16 + 10240, 16);
        push_cmd(1, 1, 0); push_cmd(2, 2, 0); push_cmd(3, 3, 0); push_cmd(12, 4, 0);
        push_cmd(20, 5, 0); push_cmd(21, 6, 0); push_cmd(25, 7, 0); push_cmd(28, 8, 0);
        drain("R1 R2 R5");

        // R7: raster-op limit, boundary 15/16
        push_cmd(13, 9, 15); push_cmd(14, 10, 16); push_cmd(26, 11, 3);
        push_cmd(27, 12, 40); push_cmd(17, 13, 0); push_cmd(9, 14, 0);
        drain("R7");

        // R6: random backpressure
        rdy_mode = 1;
        push_cmd(8, 15, 0); push_cmd(10, 16, 0); push_cmd(15, 17, 20);
        push_cmd(11, 18, 0); push_cmd(18, 19, 2); push_cmd(16, 20, 99);
        drain("R6");
        rdy_mode = 0;

        // R4: command straddles the ceiling
        init(16, 16 + 10240, 16 + 10240 - 8);
        push_cmd(3, 21, 0);
        drain("R4 wrap mid-command");
        check(mem[3] == 16 + 20, "R4 wrapped consumer", mem[3], 16 + 20);
        init(64, 64 + 10240, 64 + 10240 - 4);
        push_cmd(12, 22, 0);
        drain("R4 wrap after opcode");
        check(mem[3] == 64 + 4, "R4 wrapped consumer", mem[3], 64 + 4);

        // R3: invalid opcodes
        init(16, 16 + 10240, 16);
        put_word(0); put_word(32'h55); put_word(32'h66); commit();
        drain("R3 op 0");
        check(err_seen == 1, "R3 error pulse op 0", err_seen, 1);
        put_word(29); put_word(1); commit();
        drain("R3 op 29");
        put_word(5); put_word(1); put_word(2); commit();
        drain("R3 op 5");
        put_word(33); put_word(7); put_word(8); put_word(9); put_word(10); commit();
        drain("R3 op 33");
        check(err_seen == 4, "R3 error pulses", err_seen, 4);
        push_cmd(2, 23, 0);
        drain("R3 recovery");
        check(err_seen == 4, "R3 no error on valid op", err_seen, 4);

        // R8: sync with pending work under stall
        rdy_mode = 2;
        push_cmd(1, 24, 0); push_cmd(21, 25, 0);
        sync_req = 1'b1;
        tick(1);
        sync_req = 1'b0;
        #3;
        check(busy == 1'b1, "R8 busy set", busy, 1);
        tick(60);
        check(busy == 1'b1, "R8 busy while stalled", busy, 1);
        rdy_mode = 0;
        drain("R8 drain");
        begin
            int t = 0;
            while (busy && t < 40) begin tick(1); t++; end
        end
        check(busy == 1'b0, "R8 busy cleared", busy, 0);
        check(mem[3] == mem[2], "R8 pointers equal", mem[3], mem[2]);

        // R8: sync on an empty ring
        sync_req = 1'b1;
        tick(1);
        sync_req = 1'b0;
        #3;
        check(busy == 1'b1, "R8 busy set idle", busy, 1);
        tick(30);
        check(busy == 1'b0, "R8 busy cleared idle", busy, 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule